// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block draws a 32x32 two-colour pointer on top of a scanline pixel stream. Software positions the cursor through a packed coordinate register and describes its shape with two banks of 32 row words: a coverage mask, and a bitmap that chooses between the two overlay colours. Every pixel that enters the block carries its screen coordinates. The block decides whether the cursor covers that pixel and emits either the incoming palette index or one of the two overlay palette indices, 258 or 259.

The output is one bit wider than the input pixel, so the overlay entries above 255 can be expressed. The cursor is clipped at the right edge of a visible width that is set by a parameter. It is disabled completely when its X position lies at or beyond that width. A general-purpose misc register sits in the same register window. The block has no palette and produces no display timing.

Top module: `curs_overlay`

## Requirements
- R1: After reset, the position register reads 0xF0000000 (X = 0xF000, Y = 0), every mask and bitmap word reads 0, the misc register reads 0x02000000, and no pixel is overlaid.
- R2: A write to offset 0x8FC sets the cursor X position from bits [31:16] and the Y position from bits [15:0]. A read of 0x8FC returns {X, Y}.
- R3: Offsets 0x900 to 0x97C hold the mask words and offsets 0x980 to 0x9FC hold the bitmap words. Cursor row r lives at base + 4*r in each bank, and each word reads back as written.
- R4: A write to 0x818 stores the misc word. A read of 0x818 returns the stored word with bit 25 forced to 1.
- R5: A write to any other offset changes no register, and a read of any other offset returns 0.
- R6: outValid equals pixValid delayed by exactly one clock. outPix belongs to the pixel presented on the cycle before.
- R7: A row y is inside the cursor when Y <= y < Y + 32, computed without wrap-around, so a cursor near Y = 0xFFFF does not reappear on row 0.
- R8: Column x is inside the cursor when 0 <= x - X < 32. Within a row word, bit 31 is the leftmost cursor pixel, and the pixel at x uses bit 31 - (x - X) of row y - Y.
- R9: For a covered pixel, a mask bit of 1 selects index 259 when the bitmap bit is 1 and index 258 when it is 0. A mask bit of 0 passes the input through, zero-extended.
- R10: When X >= DISP_WIDTH, no pixel is overlaid.
- R11: A pixel with x >= DISP_WIDTH is never overlaid, so a cursor that starts near the right edge draws only min(DISP_WIDTH - X, 32) columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| pixValid | input | 1 | Input pixel qualifier |
| pixX | input | 16 | Input pixel column |
| pixY | input | 16 | Input pixel row |
| pixIn | input | PIX_W | Input palette index |
| outValid | output | 1 | Output pixel qualifier |
| outPix | output | PIX_W+1 | Output palette index, overlay indices 258 and 259 |

## Verification
The assertions assume that regAddr is word aligned. They also assume that pixX, pixY and pixIn carry defined values whenever pixValid is high, and that a register write never coincides with the pixel whose result the check examines. The stimulus drives all inputs on the falling edge and uses only aligned offsets. It performs every register write while the pixel stream is idle, so each pixel is judged against a stable cursor state. The bench steps its coordinates across the cursor edges, the right clip boundary and the top of the Y range, so that the window comparisons are exercised on both sides.

// File: rtl/curs_pkg.sv
package curs_pkg;
  localparam int CURS_DIM = 32;
  localparam int COORD_W  = 16;
  localparam int ROW_W    = $clog2(CURS_DIM);

  localparam logic [11:0] ADDR_MISC = 12'h818;
  localparam logic [11:0] ADDR_POS  = 12'h8FC;
  localparam logic [4:0]  MASK_PAGE = 5'h12;   // 0x900 >> 7
  localparam logic [4:0]  BITS_PAGE = 5'h13;   // 0x980 >> 7

  localparam logic [31:0]        MISC_FORCE  = 32'h0200_0000;
  localparam logic [COORD_W-1:0] POS_X_RESET = 16'hF000;

  typedef enum logic [2:0] {RD_NONE, RD_POS, RD_MASK, RD_BITS, RD_MISC} rdSel_e;

  typedef struct packed {
    logic             wrPos;
    logic             wrMask;
    logic             wrBits;
    logic             wrMisc;
    rdSel_e           rdSel;
    logic [ROW_W-1:0] row;
    logic [31:0]      data;
  } cursStrobe_t;
endpackage

// File: rtl/curs_ctrl.sv
module curs_ctrl
  import curs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWdata,
  output cursStrobe_t       strb
);
  logic isPos, isMisc, isMask, isBits;

  always_comb begin
    isPos  = (regAddr == ADDR_POS);
    isMisc = (regAddr == ADDR_MISC);
    isMask = (regAddr[11:7] == MASK_PAGE);
    isBits = (regAddr[11:7] == BITS_PAGE);

    strb.wrPos  = regWr && isPos;
    strb.wrMisc = regWr && isMisc;
    strb.wrMask = regWr && isMask;
    strb.wrBits = regWr && isBits;
    strb.row    = regAddr[ROW_W+1:2];
    strb.data   = regWdata;

    if (isPos)       strb.rdSel = RD_POS;
    else if (isMisc) strb.rdSel = RD_MISC;
    else if (isMask) strb.rdSel = RD_MASK;
    else if (isBits) strb.rdSel = RD_BITS;
    else             strb.rdSel = RD_NONE;
  end

  // R3 / R5: a single offset never targets two register banks at once
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrPos, strb.wrMisc, strb.wrMask, strb.wrBits}));

  // R5: a write outside the mapped windows raises no strobe
  p_unmapped_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && strb.rdSel == RD_NONE) |->
      !(strb.wrPos || strb.wrMisc || strb.wrMask || strb.wrBits));
endmodule

// File: rtl/curs_datapath.sv
module curs_datapath
  import curs_pkg::*;
#(
  parameter int DISP_WIDTH = 1024,
  parameter int PIX_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  cursStrobe_t        strb,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic [PIX_W-1:0]   pixIn,
  output logic               outValid,
  output logic [PIX_W:0]     outPix,
  output logic [31:0]        regRdata
);
  localparam int OUT_W = PIX_W + 1;
  localparam logic [COORD_W:0] WIDTH_EXT = (COORD_W+1)'(DISP_WIDTH);
  localparam logic [COORD_W:0] DIM_EXT   = (COORD_W+1)'(CURS_DIM);
  localparam logic [OUT_W-1:0] IDX_BG    = OUT_W'(258);
  localparam logic [OUT_W-1:0] IDX_FG    = OUT_W'(259);

  logic [COORD_W-1:0] cursX, cursY;
  logic [31:0]        miscReg;
  logic [31:0]        maskMem [CURS_DIM];
  logic [31:0]        bitsMem [CURS_DIM];

  // register storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cursX   <= POS_X_RESET;
      cursY   <= '0;
      miscReg <= '0;
      for (int i = 0; i < CURS_DIM; i++) begin
        maskMem[i] <= '0;
        bitsMem[i] <= '0;
      end
    end else begin
      if (strb.wrPos) begin
        cursX <= strb.data[31:16];
        cursY <= strb.data[15:0];
      end
      if (strb.wrMisc) miscReg <= strb.data;
      if (strb.wrMask) maskMem[strb.row] <= strb.data;
      if (strb.wrBits) bitsMem[strb.row] <= strb.data;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_POS:  regRdata = {cursX, cursY};
      RD_MISC: regRdata = miscReg | MISC_FORCE;
      RD_MASK: regRdata = maskMem[strb.row];
      RD_BITS: regRdata = bitsMem[strb.row];
      default: regRdata = '0;
    endcase
  end

  // hit test
  logic [COORD_W:0]   yEnd;
  logic [COORD_W-1:0] colOff;
  logic [ROW_W-1:0]   rowIdx, bitIdx;
  logic rowIn, colIn, onScreen, maskBit, fgBit, hit;

  always_comb begin
    yEnd     = {1'b0, cursY} + DIM_EXT;
    rowIn    = (pixY >= cursY) && ({1'b0, pixY} < yEnd);
    colOff   = pixX - cursX;
    onScreen = ({1'b0, cursX} < WIDTH_EXT);
    colIn    = (pixX >= cursX) && ({1'b0, colOff} < DIM_EXT) &&
               ({1'b0, pixX} < WIDTH_EXT);
    rowIdx   = ROW_W'(pixY - cursY);
    bitIdx   = ROW_W'(CURS_DIM - 1) - colOff[ROW_W-1:0];
    maskBit  = maskMem[rowIdx][bitIdx];
    fgBit    = bitsMem[rowIdx][bitIdx];
    hit      = onScreen && rowIn && colIn && maskBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= pixValid;
      if (pixValid) outPix <= hit ? (fgBit ? IDX_FG : IDX_BG) : OUT_W'(pixIn);
    end
  end

  // R6: one-cycle valid pipeline
  p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);
  p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);

  // R9: anything above the input range is one of the two overlay indices
  p_overlay_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outPix > OUT_W'(255)) |-> (outPix == IDX_BG || outPix == IDX_FG));

  // R11: pixels right of the visible width pass through
  p_clip_right_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && {1'b0, pixX} >= WIDTH_EXT) |=> outPix == OUT_W'($past(pixIn)));

  // R10: an off-screen X disables the overlay
  p_offscreen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && {1'b0, cursX} >= WIDTH_EXT) |=> outPix == OUT_W'($past(pixIn)));

  // R2: position write lands in the X field
  p_pos_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPos |=> cursX == $past(strb.data[31:16]));

  // R4: misc readback always shows the forced bit
  p_misc_force_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_MISC) |-> regRdata[25]);
endmodule

// File: rtl/curs_overlay.sv
module curs_overlay
  import curs_pkg::*;
#(
  parameter int DISP_WIDTH = 1024,
  parameter int PIX_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [11:0]        regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic [PIX_W-1:0]   pixIn,
  output logic               outValid,
  output logic [PIX_W:0]     outPix
);
  cursStrobe_t strb;

  curs_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strb     (strb)
  );

  curs_datapath #(.DISP_WIDTH(DISP_WIDTH), .PIX_W(PIX_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pixValid (pixValid),
    .pixX     (pixX),
    .pixY     (pixY),
    .pixIn    (pixIn),
    .outValid (outValid),
    .outPix   (outPix),
    .regRdata (regRdata)
  );
endmodule

// File: tb/curs_overlay_tb_top.sv
module curs_overlay_tb_top;
  localparam int W = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        pixValid = 1'b0;
  logic [15:0] pixX = '0, pixY = '0;
  logic [7:0]  pixIn = '0;
  logic        outValid;
  logic [8:0]  outPix;

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural reference state
  int          mX = 'hF000, mY = 0;
  logic [31:0] mMisc = 0;
  logic [31:0] mMask [32];
  logic [31:0] mBits [32];

  always #4 clk = ~clk;   // 125 MHz

  curs_overlay #(.DISP_WIDTH(W), .PIX_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pixValid(pixValid),
    .pixX(pixX), .pixY(pixY), .pixIn(pixIn), .outValid(outValid), .outPix(outPix)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model(int x, int y, int p);
    int r, c;
    if (mX < W && y >= mY && y < mY + 32 && x >= mX && x < mX + 32 && x < W) begin
      r = y - mY;
      c = 31 - (x - mX);
      if (mMask[r][c]) return mBits[r][c] ? 259 : 258;
    end
    return p;
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWr = 1'b0;
    if (a == 12'h8FC) begin mX = int'(d[31:16]); mY = int'(d[15:0]); end
    else if (a == 12'h818) mMisc = d;
    else if (a >= 12'h900 && a < 12'h980) mMask[(a - 12'h900) >> 2] = d;
    else if (a >= 12'h980 && a < 12'hA00) mBits[(a - 12'h980) >> 2] = d;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    regAddr = a;
    #1 chk(tag, regRdata, exp);
  endtask

  task automatic pix(int x, int y, logic [7:0] p, string tag);
    @(negedge clk);
    pixValid = 1'b1; pixX = 16'(x); pixY = 16'(y); pixIn = p;
    @(posedge clk); #1;
    pixValid = 1'b0;
    chk({tag, " valid"}, 32'(outValid), 32'd1);
    chk(tag, 32'(outPix), 32'(model(x, y, int'(p))));
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    pixValid = 1'b0;
    @(posedge clk); #1;
    chk(tag, 32'(outValid), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin mMask[i] = '0; mBits[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    chk("R1 outValid", 32'(outValid), 0);
    rd(12'h8FC, 32'hF000_0000, "R1 position");
    rd(12'h818, 32'h0200_0000, "R1 misc");
    rd(12'h900, 32'h0, "R1 mask0");
    rd(12'h9FC, 32'h0, "R1 bits31");
    pix(0, 0, 8'h11, "R1 no overlay");

    // R4 misc
    wr(12'h818, 32'h0000_0055);
    rd(12'h818, 32'h0200_0055, "R4 misc force");
    wr(12'h818, 32'h8200_0001);
    rd(12'h818, 32'h8200_0001, "R4 misc keep");

    // R5 unmapped offsets
    wr(12'h100, 32'hDEAD_BEEF);
    rd(12'h100, 32'h0, "R5 unmapped read");
    wr(12'h8F8, 32'h1234_5678);
    rd(12'h8FC, 32'hF000_0000, "R5 pos untouched");
    rd(12'h818, 32'h8200_0001, "R5 misc untouched");

    // R3 shape banks
    for (int r = 0; r < 32; r++) begin
      wr(12'(12'h900 + 4 * r), {32'hAAAA_5555} ^ (32'h1 << r) ^ 32'(r * 32'h0101_0000));
      wr(12'(12'h980 + 4 * r), 32'hFF00_FF00 ^ 32'(r * 32'h0011_0011));
    end
    rd(12'h900, mMask[0], "R3 mask row0");
    rd(12'h97C, mMask[31], "R3 mask row31");
    rd(12'h984, mBits[1], "R3 bits row1");
    rd(12'h9FC, mBits[31], "R3 bits row31");

    // R2 position
    wr(12'h8FC, {16'd100, 16'd50});
    rd(12'h8FC, 32'h0064_0032, "R2 position readback");

    // R7 R8 R9 scan across and around the cursor
    for (int y = 48; y < 84; y++)
      for (int x = 96; x < 136; x++)
        pix(x, y, 8'((x ^ y) & 8'hFF), "R9 R8 R7 scan");

    // R6 gaps
    idle("R6 idle");
    pix(100, 50, 8'h33, "R6 after gap");
    idle("R6 idle again");

    // R11 right clip
    wr(12'h8FC, {16'(W - 10), 16'd0});
    for (int y = 0; y < 3; y++)
      for (int x = W - 14; x < W + 24; x++)
        pix(x, y, 8'(x), "R11 right clip");

    // R10 X beyond width
    wr(12'h8FC, {16'(W), 16'd0});
    for (int x = W - 4; x < W + 8; x++) pix(x, 1, 8'h5A, "R10 offscreen");
    for (int x = 0; x < 4; x++) pix(x, 0, 8'hA5, "R10 offscreen left");

    // R7 no wrap near the top of the Y range
    wr(12'h8FC, {16'd8, 16'hFFF0});
    for (int x = 6; x < 42; x++) begin
      pix(x, 16'hFFFF, 8'h42, "R7 last row");
      pix(x, 0, 8'h42, "R7 no wrap row0");
      pix(x, 16'hFFEF, 8'h42, "R7 above window");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    finished = 1;
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule